// File: doc/BRIEF.md
# External Bus Chip-Select Sequencer

This block turns a simple internal request port into the pins of an external bus with separate address and data lines. Every access takes exactly one clock, with no wait states. On each clock edge with a request, it sorts the address into one of four external chip-select windows or into the internal memory range. It then updates the external address lines, the active-low chip selects, the read and write strobes and the write-data drive.

The address lines and chip selects are never forced back to an idle value between cycles. They are only changed when the access that follows calls for it:

- A run of accesses to the same window keeps that window's select low with no gap, while the address moves on.
- A step to another window switches the address and the selects on the same edge.
- An internal access releases the selects but leaves the last external address on the pins.
- A clock with no request changes neither the address nor the selects.

The strobes are the exception. They are active only in the clock of an external access.

Read data is sampled from the bus at the end of the external read clock. It is returned with a one-clock valid pulse.

Top module: `xbus_cs_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs are in their reset state: `bus_addr` is zero, every `bus_cs_n` bit is 1, `bus_rd_n` and `bus_wr_n` are 1, `bus_oe` is 0 and `rsp_valid` is 0.
- R2: Address decoding works as follows.
  - An address is internal when `(addr & INT_MASK) == INT_BASE`; the internal check takes precedence over the windows.
  - Otherwise window i matches when `((addr ^ cfg_base[i]) & cfg_mask[i]) == 0`.
  - When several windows match, the lowest index wins, and its bit i of `bus_cs_n` is driven low.
  - At most one `bus_cs_n` bit is ever low.
- R3: An external access that follows an access to the same window updates `bus_addr` to the new address. The same `bus_cs_n` bit stays low with no high clock between the two accesses.
- R4: An external access that follows an access to a different window changes `bus_addr` and `bus_cs_n` on the same clock edge.
- R5: An internal access drives every `bus_cs_n` bit high and leaves `bus_addr` at its previous value.
- R6: A clock with `req_valid` low leaves `bus_addr` and `bus_cs_n` unchanged.
- R7: Three or more consecutive accesses to one window keep its `bus_cs_n` bit low for all of those clocks.
- R8: An external address that matches no window drives `bus_addr` and the strobe, with every `bus_cs_n` bit high.
- R9: In the clock after an external read request, `bus_rd_n` is 0. In the clock after an external write request, `bus_wr_n` is 0. Both are 1 after internal or idle clocks, and they are never both 0.
- R10: In the clock after an external write request, `bus_oe` is 1 and `bus_dout` equals the request's `req_wdata`. After every other request kind, `bus_oe` is 0.
- R11: Take an external read request on edge t. On edge t+1, `rsp_valid` rises for one clock, and `rsp_rdata` holds the `bus_din` value present during the external clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| cfg_base | input | NCS x AW | Base address of each window |
| cfg_mask | input | NCS x AW | Compared-bit mask of each window |
| bus_addr | output | AW | External address lines |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DW | Write data toward the data pins |
| bus_oe | output | 1 | Output enable of the data pins |
| bus_din | input | DW | Data read from the data pins |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Returned read data |

## Verification
The address, select, strobe and data-drive outputs are registered once. Their value for a request applied before edge t is therefore due just after edge t. Read data passes through one more register and is due just after edge t+1.

The driver applies each request on a falling edge and waits for the next rising edge. It then pushes one expected item into the scoreboard. That item holds the pin state for this request and the read response owed by the request before it. The monitor pops the item on the following falling edge, so every output is compared half a period after the edge that made it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // Kind of access presented on one clock
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_INT  = 2'd1,
    ACC_EXT  = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic valid, input logic internal);
    if (!valid)        return ACC_IDLE;
    else if (internal) return ACC_INT;
    else               return ACC_EXT;
  endfunction
endpackage

// File: rtl/xbus_region_dec.sv
module xbus_region_dec #(
  parameter int AW = 20,
  parameter int NCS = 4,
  parameter logic [AW-1:0] INT_BASE = '0,
  parameter logic [AW-1:0] INT_MASK = {4'hF, {(AW-4){1'b0}}}
) (
  input  logic [AW-1:0]          addr,
  input  logic [NCS-1:0][AW-1:0] cfg_base,
  input  logic [NCS-1:0][AW-1:0] cfg_mask,
  output logic                   is_int,
  output logic [NCS-1:0]         hit
);
  logic [NCS-1:0] raw;

  assign is_int = ((addr & INT_MASK) == INT_BASE);

  for (genvar i = 0; i < NCS; i++) begin : g_win
    assign raw[i] = (((addr ^ cfg_base[i]) & cfg_mask[i]) == '0);
  end

  // lowest matching index wins
  always_comb begin
    logic found;
    found = 1'b0;
    hit   = '0;
    for (int i = 0; i < NCS; i++) begin
      if (raw[i] && !found) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  // R2
  always_comb begin
    hit_in_raw_chk: assert ((hit & ~raw) == '0 && ((raw != '0) == (hit != '0)));
  end
endmodule

// File: rtl/xbus_pin_stage.sv
module xbus_pin_stage #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  xbus_pkg::acc_kind_e kind,
  input  logic           acc_write,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_wdata,
  input  logic [NCS-1:0] acc_hit,
  output logic [AW-1:0]  bus_addr,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_rd_n,
  output logic           bus_wr_n,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_oe
);
  import xbus_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_cs_n <= '1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
    end else begin
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_oe   <= 1'b0;
      case (kind)
        ACC_INT: bus_cs_n <= '1;
        ACC_EXT: begin
          bus_addr <= acc_addr;
          bus_cs_n <= ~acc_hit;
          bus_rd_n <= acc_write;
          bus_wr_n <= !acc_write;
          bus_oe   <= acc_write;
          if (acc_write) bus_dout <= acc_wdata;
        end
        default: ;
      endcase
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_IDLE) |=> ($stable(bus_addr) && $stable(bus_cs_n)));

  // R5
  int_release_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_INT) |=> ((&bus_cs_n) && $stable(bus_addr)));

  // R3
  same_win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((kind == ACC_EXT) && (acc_hit != '0) && (acc_hit == ~bus_cs_n)) |=> $stable(bus_cs_n));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_n || bus_wr_n));

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));
endmodule

// File: rtl/xbus_rd_return.sv
module xbus_rd_return #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_issue,
  input  logic [DW-1:0] bus_din,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      pend      <= rd_issue;
      rsp_valid <= pend;
      if (pend) rsp_rdata <= bus_din;
    end
  end

  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_issue |=> ##1 rsp_valid);
endmodule

// File: rtl/xbus_cs_seq.sv
module xbus_cs_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NCS = 4,
  parameter logic [AW-1:0] INT_BASE = '0,
  parameter logic [AW-1:0] INT_MASK = {4'hF, {(AW-4){1'b0}}}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [NCS-1:0][AW-1:0] cfg_base,
  input  logic [NCS-1:0][AW-1:0] cfg_mask,
  output logic [AW-1:0]          bus_addr,
  output logic [NCS-1:0]         bus_cs_n,
  output logic                   bus_rd_n,
  output logic                   bus_wr_n,
  output logic [DW-1:0]          bus_dout,
  output logic                   bus_oe,
  input  logic [DW-1:0]          bus_din,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata
);
  import xbus_pkg::*;

  logic           is_int;
  logic [NCS-1:0] hit;
  acc_kind_e      kind;
  logic           rd_issue;

  xbus_region_dec #(
    .AW(AW), .NCS(NCS), .INT_BASE(INT_BASE), .INT_MASK(INT_MASK)
  ) u_dec (
    .addr(req_addr), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .is_int(is_int), .hit(hit)
  );

  assign kind     = classify(req_valid, is_int);
  assign rd_issue = (kind == ACC_EXT) && !req_write;

  xbus_pin_stage #(.AW(AW), .DW(DW), .NCS(NCS)) u_pins (
    .clk(clk), .rst(rst), .kind(kind), .acc_write(req_write),
    .acc_addr(req_addr), .acc_wdata(req_wdata), .acc_hit(hit),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  xbus_rd_return #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_issue(rd_issue), .bus_din(bus_din),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/sim_xbus_cs_seq.sv
module sim_xbus_cs_seq;
  localparam int  AW = 20;
  localparam int  DW = 16;
  localparam int  NCS = 4;
  localparam time CLK_PERIOD = 10;
  localparam logic [DW-1:0] DIN_KEY = 16'hA5C3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [NCS-1:0][AW-1:0] cfg_base, cfg_mask;
  logic [AW-1:0] bus_addr;
  logic [NCS-1:0] bus_cs_n;
  logic bus_rd_n, bus_wr_n, bus_oe, rsp_valid;
  logic [DW-1:0] bus_dout, bus_din, rsp_rdata;

  // external memory model: data is a function of the address on the pins
  assign bus_din = bus_addr[DW-1:0] ^ DIN_KEY;

  xbus_cs_seq #(.AW(AW), .DW(DW), .NCS(NCS)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic [NCS-1:0] cs_n;
    logic           rd_n;
    logic           wr_n;
    logic           oe;
    logic [DW-1:0]  dout;
    logic           rv;
    logic [DW-1:0]  rdata;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [AW-1:0]  m_addr = '0;
  logic [NCS-1:0] m_cs_n = '1;
  logic           m_rd_pend = 1'b0;
  logic [AW-1:0]  m_rd_addr = '0;

  function automatic bit ref_int(input logic [AW-1:0] a);
    return a[AW-1:AW-4] == 4'h0;
  endfunction

  function automatic logic [NCS-1:0] ref_hit(input logic [AW-1:0] a);
    for (int i = 0; i < NCS; i++)
      if ((a & cfg_mask[i]) == (cfg_base[i] & cfg_mask[i])) return NCS'(1) << i;
    return '0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    exp_t e;
    bit ext;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    ext = v && !ref_int(a);
    e.rv    = m_rd_pend;
    e.rdata = m_rd_addr[DW-1:0] ^ DIN_KEY;
    m_rd_pend = ext && !w;
    m_rd_addr = a;
    if (v) begin
      if (!ext) m_cs_n = '1;
      else begin
        m_addr = a;
        m_cs_n = ~ref_hit(a);
      end
    end
    e.addr = m_addr;
    e.cs_n = m_cs_n;
    e.rd_n = !(ext && !w);
    e.wr_n = !(ext && w);
    e.oe   = ext && w;
    e.dout = d;
    q.push_back(e);
    tq.push_back(tag);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      chk(t, "bus_addr", 32'(bus_addr), 32'(e.addr));
      chk(t, "bus_cs_n", 32'(bus_cs_n), 32'(e.cs_n));
      chk("R9", "strobes", {30'd0, bus_rd_n, bus_wr_n}, {30'd0, e.rd_n, e.wr_n});
      chk("R10", "bus_oe", 32'(bus_oe), 32'(e.oe));
      if (e.oe) chk("R10", "bus_dout", 32'(bus_dout), 32'(e.dout));
      chk("R11", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
      if (e.rv) chk("R11", "rsp_rdata", 32'(rsp_rdata), 32'(e.rdata));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    cfg_base[0] = 20'h10000; cfg_mask[0] = 20'hF0000;
    cfg_base[1] = 20'h20000; cfg_mask[1] = 20'hF0000;
    cfg_base[2] = 20'h30000; cfg_mask[2] = 20'hF8000;
    cfg_base[3] = 20'h30000; cfg_mask[3] = 20'hF0000;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "bus_addr", 32'(bus_addr), 32'd0);
    chk("R1", "bus_cs_n", 32'(bus_cs_n), 32'hF);
    chk("R1", "strobes", {30'd0, bus_rd_n, bus_wr_n}, 32'd3);
    chk("R1", "bus_oe", 32'(bus_oe), 32'd0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    step(1, 0, 20'h10010, 16'h0000, "R2");   // window 0 read
    step(1, 1, 20'h10020, 16'hBEEF, "R3");   // same window write
    step(1, 0, 20'h10030, 16'h0000, "R7");   // third in run
    step(1, 0, 20'h10040, 16'h0000, "R7");   // fourth in run
    step(1, 1, 20'h20000, 16'h1234, "R4");   // other window
    step(1, 0, 20'h01234, 16'h0000, "R5");   // internal read
    step(0, 0, 20'h10000, 16'h0000, "R6");   // idle
    step(0, 1, 20'h20000, 16'h5555, "R6");   // idle, write flag ignored
    step(1, 0, 20'h30100, 16'h0000, "R2");   // overlap: window 2 wins
    step(1, 1, 20'h38000, 16'hCAFE, "R4");   // window 3
    step(0, 0, 20'h00000, 16'h0000, "R6");
    step(1, 0, 20'h80000, 16'h0000, "R8");   // no window
    step(1, 1, 20'h00400, 16'h7777, "R5");   // internal write, pins not driven
    step(1, 0, 20'h2ABCD, 16'h0000, "R11");  // window 1 read
    step(1, 0, 20'h2ABCE, 16'h0000, "R3");   // back to back reads
    step(0, 0, 20'h00000, 16'h0000, "R6");
    step(0, 0, 20'h00000, 16'h0000, "R6");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule